// File: doc/BRIEF.md
# Edge-Triggered Up/Down Event Counter

This block counts events presented as a level condition. It keeps a signed accumulator that moves by one each time the condition goes from low to high. A direction select sets whether that step adds one or subtracts one. While the condition stays high, stays low or drops, the accumulator keeps its value. The value returns to zero only through an explicit clear request or the block reset.

A signed preset is compared against the accumulator all the time. A done flag is high whenever the accumulator is greater than or equal to the preset, so the flag works the same way for negative targets reached by counting down. Two enable flags show, for the selected direction, whether the condition is currently asserted. The accumulator stops at the signed limits instead of wrapping, so a long run of events can never flip the sign of the count.

Top module: `edge_event_counter`

## Requirements
- R1: With `dir_down_i` = 0 (up), a cycle in which `cond_i` is high and was low in the previous cycle raises `acc_o` by one after the next clock edge.
- R2: With `dir_down_i` = 1 (down), the same low-to-high transition lowers `acc_o` by one after the next clock edge.
- R3: When `cond_i` is steady high, steady low or falling, `acc_o` keeps its value.
- R4: `done_o` is high exactly when `acc_o`, read as two's complement, is greater than or equal to `preset_i`, also read as two's complement.
- R5: `up_en_o` equals `cond_i` while `dir_down_i` = 0 and is low otherwise. `dn_en_o` equals `cond_i` while `dir_down_i` = 1 and is low otherwise. The two are never high together.
- R6: `clear_i` high at a clock edge makes `acc_o` zero after that edge. A counting transition in the same cycle is discarded.
- R7: `acc_o` saturates at the largest positive value (2^(W-1)-1) when counting up and at the most negative value (-2^(W-1)) when counting down.
- R8: `rst_n` low clears `acc_o` to zero at once. After release, a condition that was already high is not counted until it has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_i | input | 1 | Event condition level |
| dir_down_i | input | 1 | Count direction: 0 up, 1 down |
| preset_i | input | W | Signed target for the done comparison |
| clear_i | input | 1 | Synchronous clear request for the accumulator |
| acc_o | output | W | Signed accumulator |
| up_en_o | output | 1 | Condition high in up mode |
| dn_en_o | output | 1 | Condition high in down mode |
| done_o | output | 1 | Accumulator greater than or equal to preset |

## Verification
The bench builds the counter with W = 4, which limits the accumulator to the range -8 to +7. A dozen event pulses is then enough to drive it into both saturation limits and confirm that it stops there. The narrow width also lets the vector table use negative presets near the bottom of the range, so the signed done comparison is tested on both sides of zero. The default 16-bit width differs only in the value of its limits.

// File: rtl/edge_event_counter_pkg.sv
package edge_event_counter_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } count_dir_e;

endpackage

// File: rtl/evc_edge_detect.sv
module evc_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  output logic rise_o
);

  logic cond_q;

  // History starts high so a level already true at reset release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b1;
    else        cond_q <= cond_i;
  end

  assign rise_o = cond_i & ~cond_q;

endmodule

// File: rtl/evc_accum.sv
module evc_accum
  import edge_event_counter_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise_i,
  input  logic                clear_i,
  input  count_dir_e          dir_i,
  output logic signed [W-1:0] acc_o
);

  localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0]        ONE  = {{(W-1){1'b0}}, 1'b1};

  function automatic logic signed [W-1:0] step_sat(
    input logic signed [W-1:0] a,
    input count_dir_e          d
  );
    if (d == DIR_UP) return (a == SMAX) ? a : a + ONE;
    else             return (a == SMIN) ? a : a - ONE;
  endfunction

  logic signed [W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (rise_i)  acc_q <= step_sat(acc_q, dir_i);
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/evc_status.sv
module evc_status
  import edge_event_counter_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                cond_i,
  input  count_dir_e          dir_i,
  input  logic signed [W-1:0] acc_i,
  input  logic signed [W-1:0] preset_i,
  output logic                up_en_o,
  output logic                dn_en_o,
  output logic                done_o
);

  function automatic logic reached(
    input logic signed [W-1:0] a,
    input logic signed [W-1:0] p
  );
    return (a >= p);
  endfunction

  assign up_en_o = cond_i & (dir_i == DIR_UP);
  assign dn_en_o = cond_i & (dir_i == DIR_DOWN);
  assign done_o  = reached(acc_i, preset_i);

endmodule

// File: rtl/edge_event_counter.sv
module edge_event_counter
  import edge_event_counter_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cond_i,
  input  logic                dir_down_i,
  input  logic signed [W-1:0] preset_i,
  input  logic                clear_i,
  output logic signed [W-1:0] acc_o,
  output logic                up_en_o,
  output logic                dn_en_o,
  output logic                done_o
);

  logic       rise_w;
  count_dir_e dir_w;

  assign dir_w = count_dir_e'(dir_down_i);

  evc_edge_detect edge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond_i (cond_i),
    .rise_o (rise_w)
  );

  evc_accum #(.W(W)) accum_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (rise_w),
    .clear_i (clear_i),
    .dir_i   (dir_w),
    .acc_o   (acc_o)
  );

  evc_status #(.W(W)) status_i (
    .cond_i   (cond_i),
    .dir_i    (dir_w),
    .acc_i    (acc_o),
    .preset_i (preset_i),
    .up_en_o  (up_en_o),
    .dn_en_o  (dn_en_o),
    .done_o   (done_o)
  );

endmodule

// File: rtl/edge_event_counter_chk.sv
module edge_event_counter_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cond_i,
  input logic                dir_down_i,
  input logic                clear_i,
  input logic                rise_w,
  input logic signed [W-1:0] acc_o,
  input logic                up_en_o,
  input logic                dn_en_o
);

  localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w && !clear_i && !dir_down_i && acc_o != SMAX) |=> (acc_o == $past(acc_o) + 1'b1));

  a_r2_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w && !clear_i && dir_down_i && acc_o != SMIN) |=> (acc_o == $past(acc_o) - 1'b1));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_w && !clear_i) |=> $stable(acc_o));

  a_r5_en_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({up_en_o, dn_en_o}) <= 1);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (acc_o == '0));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w && !clear_i && !dir_down_i && acc_o == SMAX) |=> (acc_o == SMAX));

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w && !clear_i && dir_down_i && acc_o == SMIN) |=> (acc_o == SMIN));

  a_r8_rise_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |-> cond_i);

endmodule

bind edge_event_counter edge_event_counter_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cond_i     (cond_i),
  .dir_down_i (dir_down_i),
  .clear_i    (clear_i),
  .rise_w     (rise_w),
  .acc_o      (acc_o),
  .up_en_o    (up_en_o),
  .dn_en_o    (dn_en_o)
);

// File: tb/edge_event_counter_tb_top.sv
module edge_event_counter_tb_top;

  localparam int W  = 4;
  localparam int NV = 16;

  // Row layout: {cond, dir_down, clear, 1'b0, preset[3:0], expected acc[3:0]}
  localparam logic [11:0] VEC [NV] = '{
    12'b0000_0011_0000,  // low: history becomes low
    12'b1000_0011_0001,  // R1 rise up -> 1
    12'b1000_0011_0001,  // R3 steady high
    12'b0000_0011_0001,  // R3 falling
    12'b1000_0011_0010,  // R1 -> 2
    12'b0000_0011_0010,
    12'b1000_0011_0011,  // R1 -> 3, done
    12'b0100_0011_0011,
    12'b1100_0011_0010,  // R2 -> 2
    12'b0100_0011_0010,
    12'b1100_0011_0001,  // R2 -> 1
    12'b0000_0011_0001,
    12'b1010_0011_0000,  // R6 clear beats edge
    12'b0000_0011_0000,
    12'b1100_1110_1111,  // R2 -> -1, preset -2
    12'b0100_1110_1111   // R4 -1 >= -2
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                cond = 1'b0;
  logic                dir_down = 1'b0;
  logic                clear = 1'b0;
  logic signed [W-1:0] preset = 4'sd1;
  logic signed [W-1:0] acc;
  logic                up_en, dn_en, done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  edge_event_counter #(.W(W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_i     (cond),
    .dir_down_i (dir_down),
    .preset_i   (preset),
    .clear_i    (clear),
    .acc_o      (acc),
    .up_en_o    (up_en),
    .dn_en_o    (dn_en),
    .done_o     (done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample 5 ns later.
  task automatic cyc(input logic c, input logic d, input logic clr);
    @(negedge clk);
    cond = c; dir_down = d; clear = clr;
    @(posedge clk);
    #5;
  endtask

  task automatic pulse(input logic d);
    cyc(1'b1, d, 1'b0);
    cyc(1'b0, d, 1'b0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    #35;
    // R8 reset state
    check("R8 acc in reset", int'(acc), 0);
    check("R4 done in reset (0>=1)", int'(done), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      preset = $signed(v[7:4]);
      cyc(v[11], v[10], v[9]);
      check($sformatf("R1/R2/R3/R6 row %0d acc", i), int'(acc), int'($signed(v[3:0])));
      check($sformatf("R4 row %0d done", i), int'(done),
            int'($signed(v[3:0]) >= $signed(v[7:4])));
      check($sformatf("R5 row %0d up_en", i), int'(up_en), int'(v[11] & ~v[10]));
      check($sformatf("R5 row %0d dn_en", i), int'(dn_en), int'(v[11] & v[10]));
    end

    // R7 saturate at +7
    cyc(1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 10; k++) pulse(1'b0);
    check("R7 upper limit", int'(acc), 7);
    preset = 4'sd7;
    #1;
    check("R4 done at preset 7", int'(done), 1);

    // R7 saturate at -8
    for (int k = 0; k < 20; k++) pulse(1'b1);
    check("R7 lower limit", int'(acc), -8);
    preset = -4'sd8;
    #1;
    check("R4 done at -8 >= -8", int'(done), 1);
    preset = -4'sd7;
    #1;
    check("R4 not done at -8 < -7", int'(done), 0);

    // R6 clear with static condition
    cyc(1'b0, 1'b1, 1'b1);
    check("R6 clear while idle", int'(acc), 0);
    cyc(1'b0, 1'b0, 1'b0);
    pulse(1'b0);
    pulse(1'b0);
    check("R1 two pulses after clear", int'(acc), 2);

    // R8 async reset mid-run with condition held high through release
    @(negedge clk);
    cond = 1'b1;
    #2 rst_n = 1'b0;
    #1;
    check("R8 async clear", int'(acc), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    check("R8 high at release not counted", int'(acc), 0);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    check("R8 fresh edge counts", int'(acc), 1);

    summary();
  end

endmodule